// File: doc/BRIEF.md
# Ring Product-Term Group Allocator

This block routes pre-evaluated product-term groups between neighbouring logic cells, so that a cell whose function needs more terms than it owns can use spare groups from the cells beside it. Each cell owns two groups of four product terms, a lower group and an upper group. A group counts as true when any of its four terms is true. Every group carries a static two-bit destination code. The code either keeps the group in its owner's sum or sends it to one ring neighbour. The cells are arranged in independent rings, and each ring wraps around at its ends. For each cell the block produces one registered sum-of-products bit: the OR of all the groups that reach that cell.

A configuration that sends a group in the wrong direction, or to both neighbours, is flagged as an error for its ring. The routing that results in that case is still fully defined. The block is meant to sit between a product-term array and the cell registers. Ring size, ring count and group width are parameters.

Top module: `pta_ring_alloc`

## Requirements
- R1: While `rst_n` is low, `sop_out`, `ring_error` and `config_error` are all 0. After reset, each output shows the inputs sampled at the previous rising clock edge, which is one cycle of latency.
- R2: A group is true when at least one of its terms is true. A cell's `sop_out` bit is the OR of every group routed to that cell.
- R3: A group whose destination code is 00 (keep) is part of its owner's sum. Cells are numbered ring by ring. Cell c uses terms [4c+3:4c] of `pt_lo` / `pt_hi` and code bits [2c+1:2c] of `dest_lo` / `dest_hi`.
- R4: A lower group with code 01 is removed from its owner's sum and added to the sum of the owner's previous neighbour.
- R5: An upper group with code 10 is removed from its owner's sum and added to the sum of the owner's next neighbour.
- R6: Adjacency wraps within a ring. The previous neighbour of the first cell in a ring is the last cell of that ring, and the next neighbour of the last cell is the first cell.
- R7: Groups never cross from one ring to another. Ring k holds global cells k*RING_CELLS to k*RING_CELLS+RING_CELLS-1.
- R8: A cell that has lent both of its groups and receives no group has an output of 0, whatever its terms are.
- R9: `ring_error[k]` is set when any lower group in ring k has code bit 1 set (code 10 or 11), or any upper group in ring k has code bit 0 set (code 01 or 11). `config_error` is the OR of all `ring_error` bits. Both follow the one-cycle latency of R1.
- R10: Routing under a bad code is defined. A lower group with code 11 goes to its previous neighbour only. A lower group with code 10 reaches no cell. An upper group with code 11 goes to its next neighbour only. An upper group with code 01 reaches no cell.
- R11: A cell that keeps both of its groups, and also receives the upper group of its previous neighbour and the lower group of its next neighbour, outputs 1 when any one of those 16 terms is true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_lo | input | NUM_RINGS*RING_CELLS*GROUP_TERMS | Evaluated terms of every cell's lower group |
| pt_hi | input | NUM_RINGS*RING_CELLS*GROUP_TERMS | Evaluated terms of every cell's upper group |
| dest_lo | input | 2*NUM_RINGS*RING_CELLS | Destination code of each lower group |
| dest_hi | input | 2*NUM_RINGS*RING_CELLS | Destination code of each upper group |
| sop_out | output | NUM_RINGS*RING_CELLS | Registered sum of products, one bit per cell |
| ring_error | output | NUM_RINGS | Registered per-ring bad-configuration flag |
| config_error | output | 1 | OR of all ring error flags |

## Verification
Routing and error detection can happen in the same cycle. A bad destination code flags its ring, and it also changes which sums the group reaches. The bench provokes both at once. It gives a lower group code 10 and an upper group code 11, each with live terms, in different rings. It then judges three things: the per-ring error bits, the cell that still receives the legal half of the code, and the cells that must now read 0. The wraparound neighbours at the ring seams are driven in the same cycle as lending inside the ring, to show that nothing leaks into the other ring.

// File: rtl/ptalloc_pkg.sv
package ptalloc_pkg;

  typedef enum logic [1:0] {
    DST_KEEP = 2'b00,
    DST_PREV = 2'b01,
    DST_NEXT = 2'b10,
    DST_BOTH = 2'b11
  } pt_dest_e;

  // Ring neighbours with wraparound
  function automatic int unsigned ring_prev(int unsigned idx, int unsigned n);
    return (idx == 0) ? n - 1 : idx - 1;
  endfunction

  function automatic int unsigned ring_next(int unsigned idx, int unsigned n);
    return (idx == n - 1) ? 0 : idx + 1;
  endfunction

  // A lower group may only travel backwards, an upper group only forwards
  function automatic logic dest_illegal(logic [1:0] code, logic is_upper);
    return is_upper ? code[0] : code[1];
  endfunction

  function automatic logic goes_prev(logic [1:0] code);
    return code[0];
  endfunction

  function automatic logic goes_next(logic [1:0] code);
    return code[1];
  endfunction

  function automatic logic is_kept(logic [1:0] code);
    return code == DST_KEEP;
  endfunction

endpackage

// File: rtl/pta_group_or.sv
module pta_group_or #(
  parameter int GROUP_TERMS = 4
) (
  input  logic [GROUP_TERMS-1:0] terms,
  output logic                   hit
);
  assign hit = |terms;
endmodule

// File: rtl/pta_cfg_check.sv
module pta_cfg_check #(
  parameter int RING_CELLS = 6
) (
  input  logic [2*RING_CELLS-1:0] dest_lo,
  input  logic [2*RING_CELLS-1:0] dest_hi,
  output logic                    ring_bad
);
  import ptalloc_pkg::*;

  logic [RING_CELLS-1:0] cell_bad;

  for (genvar i = 0; i < RING_CELLS; i++) begin : g_cell
    assign cell_bad[i] = dest_illegal(dest_lo[2*i +: 2], 1'b0)
                       | dest_illegal(dest_hi[2*i +: 2], 1'b1);
  end

  assign ring_bad = |cell_bad;
endmodule

// File: rtl/pta_ring.sv
module pta_ring #(
  parameter int RING_CELLS  = 6,
  parameter int GROUP_TERMS = 4
) (
  input  logic [RING_CELLS*GROUP_TERMS-1:0] pt_lo,
  input  logic [RING_CELLS*GROUP_TERMS-1:0] pt_hi,
  input  logic [2*RING_CELLS-1:0]           dest_lo,
  input  logic [2*RING_CELLS-1:0]           dest_hi,
  output logic [RING_CELLS-1:0]             lo_hit,
  output logic [RING_CELLS-1:0]             hi_hit,
  output logic [RING_CELLS-1:0]             keep_lo,
  output logic [RING_CELLS-1:0]             keep_hi,
  output logic [RING_CELLS-1:0]             take_prev,
  output logic [RING_CELLS-1:0]             take_next,
  output logic [RING_CELLS-1:0]             cell_sum
);
  import ptalloc_pkg::*;

  for (genvar i = 0; i < RING_CELLS; i++) begin : g_cell
    localparam int unsigned PV = ring_prev(i, RING_CELLS);
    localparam int unsigned NX = ring_next(i, RING_CELLS);

    pta_group_or #(.GROUP_TERMS(GROUP_TERMS)) u_lo (
      .terms(pt_lo[i*GROUP_TERMS +: GROUP_TERMS]),
      .hit  (lo_hit[i])
    );
    pta_group_or #(.GROUP_TERMS(GROUP_TERMS)) u_hi (
      .terms(pt_hi[i*GROUP_TERMS +: GROUP_TERMS]),
      .hit  (hi_hit[i])
    );

    assign keep_lo[i]   = is_kept(dest_lo[2*i +: 2]);
    assign keep_hi[i]   = is_kept(dest_hi[2*i +: 2]);
    // previous neighbour's upper group sent forward to this cell
    assign take_prev[i] = goes_next(dest_hi[2*PV +: 2]);
    // next neighbour's lower group sent backward to this cell
    assign take_next[i] = goes_prev(dest_lo[2*NX +: 2]);

    assign cell_sum[i] = (keep_lo[i]   & lo_hit[i])
                       | (keep_hi[i]   & hi_hit[i])
                       | (take_prev[i] & hi_hit[PV])
                       | (take_next[i] & lo_hit[NX]);
  end
endmodule

// File: rtl/pta_ring_alloc.sv
module pta_ring_alloc #(
  parameter int RING_CELLS  = 6,
  parameter int NUM_RINGS   = 2,
  parameter int GROUP_TERMS = 4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [NUM_RINGS*RING_CELLS*GROUP_TERMS-1:0] pt_lo,
  input  logic [NUM_RINGS*RING_CELLS*GROUP_TERMS-1:0] pt_hi,
  input  logic [2*NUM_RINGS*RING_CELLS-1:0]         dest_lo,
  input  logic [2*NUM_RINGS*RING_CELLS-1:0]         dest_hi,
  output logic [NUM_RINGS*RING_CELLS-1:0]           sop_out,
  output logic [NUM_RINGS-1:0]                      ring_error,
  output logic                                      config_error
);
  import ptalloc_pkg::*;

  localparam int TOTAL_CELLS = NUM_RINGS * RING_CELLS;
  localparam int RING_TERMS  = RING_CELLS * GROUP_TERMS;
  localparam logic [2*RING_CELLS-1:0] LO_BAD_MASK = {RING_CELLS{2'b10}};
  localparam logic [2*RING_CELLS-1:0] HI_BAD_MASK = {RING_CELLS{2'b01}};

  // Internal events brought out for the checks
  logic [TOTAL_CELLS-1:0] lo_hit, hi_hit;
  logic [TOTAL_CELLS-1:0] keep_lo, keep_hi;
  logic [TOTAL_CELLS-1:0] take_prev, take_next;
  logic [TOTAL_CELLS-1:0] sum_comb;
  logic [TOTAL_CELLS-1:0] cell_idle;
  logic [NUM_RINGS-1:0]   ring_bad;

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
    localparam int B = r * RING_CELLS;

    pta_ring #(.RING_CELLS(RING_CELLS), .GROUP_TERMS(GROUP_TERMS)) u_ring (
      .pt_lo    (pt_lo[B*GROUP_TERMS +: RING_TERMS]),
      .pt_hi    (pt_hi[B*GROUP_TERMS +: RING_TERMS]),
      .dest_lo  (dest_lo[2*B +: 2*RING_CELLS]),
      .dest_hi  (dest_hi[2*B +: 2*RING_CELLS]),
      .lo_hit   (lo_hit[B +: RING_CELLS]),
      .hi_hit   (hi_hit[B +: RING_CELLS]),
      .keep_lo  (keep_lo[B +: RING_CELLS]),
      .keep_hi  (keep_hi[B +: RING_CELLS]),
      .take_prev(take_prev[B +: RING_CELLS]),
      .take_next(take_next[B +: RING_CELLS]),
      .cell_sum (sum_comb[B +: RING_CELLS])
    );

    pta_cfg_check #(.RING_CELLS(RING_CELLS)) u_chk (
      .dest_lo (dest_lo[2*B +: 2*RING_CELLS]),
      .dest_hi (dest_hi[2*B +: 2*RING_CELLS]),
      .ring_bad(ring_bad[r])
    );

    // R9: ring flag follows the codes seen one cycle earlier
    a_r9_ring_flag_from_codes: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ring_error[r] ==
        $past((|(dest_lo[2*B +: 2*RING_CELLS] & LO_BAD_MASK)) |
              (|(dest_hi[2*B +: 2*RING_CELLS] & HI_BAD_MASK))));

    for (genvar i = 0; i < RING_CELLS; i++) begin : g_cell
      localparam int C  = B + i;
      localparam int PG = B + int'(ring_prev(i, RING_CELLS));
      localparam int NG = B + int'(ring_next(i, RING_CELLS));

      assign cell_idle[C] = !keep_lo[C] && !keep_hi[C] && !take_prev[C] && !take_next[C];

      // R8: nothing routed in means a zero sum
      a_r8_idle_cell_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cell_idle[C]) |-> !sop_out[C]);

      // R2: a true output needs a true group within reach
      a_r2_sop_needs_reachable_hit: assert property (@(posedge clk) disable iff (!rst_n)
        sop_out[C] |-> $past(lo_hit[C] | hi_hit[C] | hi_hit[PG] | lo_hit[NG]));

      // R4: a lower group has at most one user
      a_r4_lo_single_user: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({keep_lo[C], take_next[PG]}));

      // R5: an upper group has at most one user
      a_r5_hi_single_user: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({keep_hi[C], take_prev[NG]}));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sop_out      <= '0;
      ring_error   <= '0;
      config_error <= 1'b0;
    end else begin
      sop_out      <= sum_comb;
      ring_error   <= ring_bad;
      config_error <= |ring_bad;
    end
  end

  // R9: the summary flag agrees with the per-ring flags
  a_r9_summary_is_or: assert property (@(posedge clk) disable iff (!rst_n)
    config_error == (|ring_error));

endmodule

// File: tb/tb_pta_ring_alloc.sv
`timescale 1ns/1ps
module tb_pta_ring_alloc;
  localparam int N  = 6;
  localparam int NR = 2;
  localparam int GT = 4;
  localparam int C  = N * NR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [C*GT-1:0] pt_lo = '0, pt_hi = '0;
  logic [2*C-1:0]  dest_lo = '0, dest_hi = '0;
  logic [C-1:0]    sop_out;
  logic [NR-1:0]   ring_error;
  logic            config_error;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  pta_ring_alloc #(.RING_CELLS(N), .NUM_RINGS(NR), .GROUP_TERMS(GT)) dut (
    .clk(clk), .rst_n(rst_n), .pt_lo(pt_lo), .pt_hi(pt_hi),
    .dest_lo(dest_lo), .dest_hi(dest_hi),
    .sop_out(sop_out), .ring_error(ring_error), .config_error(config_error)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference: walk every group and deliver it where its code points
  task automatic model(output logic [C-1:0] es, output logic [NR-1:0] er);
    es = '0;
    er = '0;
    for (int g = 0; g < C; g++) begin
      int r = g / N;
      int p = r * N + ((g % N) + N - 1) % N;
      int n = r * N + ((g % N) + 1) % N;
      logic lv = |pt_lo[g*GT +: GT];
      logic hv = |pt_hi[g*GT +: GT];
      logic [1:0] dl = dest_lo[g*2 +: 2];
      logic [1:0] dh = dest_hi[g*2 +: 2];
      if (dl == 2'b00) es[g] |= lv;
      if (dl == 2'b01 || dl == 2'b11) es[p] |= lv;
      if (dh == 2'b00) es[g] |= hv;
      if (dh == 2'b10 || dh == 2'b11) es[n] |= hv;
      if (dl == 2'b10 || dl == 2'b11 || dh == 2'b01 || dh == 2'b11) er[r] = 1'b1;
    end
  endtask

  task automatic step_check(string req);
    logic [C-1:0] es;
    logic [NR-1:0] er;
    @(posedge clk);
    @(negedge clk);
    model(es, er);
    check(req, "sop_out", 32'(sop_out), 32'(es));
    check(req, "ring_error", 32'(ring_error), 32'(er));
    check(req, "config_error", 32'(config_error), 32'(|er));
  endtask

  task automatic clear_all();
    pt_lo = '0; pt_hi = '0; dest_lo = '0; dest_hi = '0;
  endtask

  task automatic t_reset();
    pt_lo = '1; pt_hi = '1; dest_lo = {C{2'b11}};
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "sop_out in reset", 32'(sop_out), 32'd0);
    check("R1", "ring_error in reset", 32'(ring_error), 32'd0);
    check("R1", "config_error in reset", 32'(config_error), 32'd0);
    clear_all();
    pt_lo = '1;
    rst_n = 1'b1;
    step_check("R1");
    check("R1", "all kept", 32'(sop_out), 32'hFFF);
    // latency: new input is not visible before the next edge
    pt_lo = '0;
    #5;
    check("R1", "before edge", 32'(sop_out), 32'hFFF);
    step_check("R1");
    check("R1", "after edge", 32'(sop_out), 32'h000);
  endtask

  task automatic t_own_groups();
    clear_all();
    for (int t = 0; t < GT; t++) begin
      pt_lo = '0; pt_hi = '0;
      for (int c = 0; c < C; c += 2) pt_lo[c*GT + t] = 1'b1;
      for (int c = 0; c < C; c += 3) pt_hi[c*GT + (GT-1-t)] = 1'b1;
      step_check("R2");
    end
    pt_lo = '0; pt_hi = '0;
    pt_hi[7*GT + 2] = 1'b1;
    step_check("R3");
    check("R3", "cell7 own upper", 32'(sop_out), 32'h080);
  endtask

  task automatic t_lend_lo();
    clear_all();
    pt_lo[3*GT + 1] = 1'b1;
    dest_lo[3*2 +: 2] = 2'b01;
    step_check("R4");
    check("R4", "lower to previous", 32'(sop_out), 32'h004);
  endtask

  task automatic t_lend_hi();
    clear_all();
    pt_hi[2*GT + 3] = 1'b1;
    dest_hi[2*2 +: 2] = 2'b10;
    step_check("R5");
    check("R5", "upper to next", 32'(sop_out), 32'h008);
  endtask

  task automatic t_wrap_and_rings();
    clear_all();
    pt_lo[0*GT] = 1'b1;  dest_lo[0 +: 2]    = 2'b01;
    pt_hi[11*GT] = 1'b1; dest_hi[11*2 +: 2] = 2'b10;
    step_check("R6");
    check("R6", "seams wrap", 32'(sop_out), 32'h060);
    clear_all();
    pt_hi[5*GT + 1] = 1'b1; dest_hi[5*2 +: 2] = 2'b10;
    pt_lo[6*GT + 2] = 1'b1; dest_lo[6*2 +: 2] = 2'b01;
    step_check("R7");
    check("R7", "no cross-ring", 32'(sop_out), 32'h801);
  endtask

  task automatic t_idle();
    clear_all();
    pt_lo = '1; pt_hi = '1;
    dest_lo[4*2 +: 2] = 2'b01;
    dest_hi[4*2 +: 2] = 2'b10;
    step_check("R8");
    check("R8", "idle cell zero", 32'(sop_out[4]), 32'd0);
  endtask

  task automatic t_full();
    clear_all();
    dest_hi[7*2 +: 2] = 2'b10;
    dest_lo[9*2 +: 2] = 2'b01;
    step_check("R11");
    check("R11", "no term", 32'(sop_out[8]), 32'd0);
    for (int g = 0; g < 4; g++) begin
      for (int t = 0; t < GT; t++) begin
        pt_lo = '0; pt_hi = '0;
        case (g)
          0: pt_lo[8*GT + t] = 1'b1;
          1: pt_hi[8*GT + t] = 1'b1;
          2: pt_hi[7*GT + t] = 1'b1;
          default: pt_lo[9*GT + t] = 1'b1;
        endcase
        step_check("R11");
        check("R11", "single term", 32'(sop_out[8]), 32'd1);
      end
    end
  endtask

  task automatic t_errors();
    clear_all();
    pt_lo[1*GT] = 1'b1; dest_lo[1*2 +: 2] = 2'b10;
    step_check("R10");
    check("R9", "ring0 flag", 32'(ring_error), 32'h1);
    check("R10", "lower code 10 dropped", 32'(sop_out), 32'h000);
    pt_hi[7*GT + 3] = 1'b1; dest_hi[7*2 +: 2] = 2'b11;
    step_check("R10");
    check("R9", "both flags", 32'(ring_error), 32'h3);
    check("R10", "upper code 11 forward", 32'(sop_out), 32'h100);
    clear_all();
    pt_lo[3*GT] = 1'b1; dest_lo[3*2 +: 2] = 2'b11;
    pt_hi[10*GT] = 1'b1; dest_hi[10*2 +: 2] = 2'b01;
    step_check("R10");
    check("R10", "lower 11 back, upper 01 dropped", 32'(sop_out), 32'h004);
    check("R9", "summary", 32'(config_error), 32'd1);
    clear_all();
    step_check("R9");
    check("R9", "flags clear", 32'(ring_error), 32'h0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_own_groups();
    t_lend_lo();
    t_lend_hi();
    t_wrap_and_rings();
    t_idle();
    t_full();
    t_errors();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end
endmodule